// File: doc/BRIEF.md
# Size-Merging Integer ALU with Masked Condition Flags

This block executes one integer micro-operation per clock. It takes a first source, a second operand that is either a register value or an 8-bit immediate, an operand size of 1, 2, 4 or 8 bytes, and an opcode. The opcodes are add, add-with-carry, subtract, subtract-with-borrow, AND, OR, XOR and conditional move. The result is computed at the selected size and then folded into the previous destination value. The merged value is registered on the next rising edge.

The block holds a five-bit condition-flag register. Each operation computes a candidate set of flags, and a per-bit update mask decides which stored flags take the new value. Add-with-carry and subtract-with-borrow consume the stored carry. Subtract-type flags come from the same adder, which is fed the inverted second operand. The conditional move tests a selectable condition against the stored flags. It never alters the flags, and when its condition fails the destination keeps its old value.

Top module: `szmerge_alu`

## Requirements
- R1: When `use_imm` is 1, the zero-extended `imm` replaces `src2` as the second operand. Every opcode behaves identically in both forms.
- R2: Opcode encoding is ADD=0, ADC=1, SUB=2, SBB=3, AND=4, OR=5, XOR=6, MOV=7. ADD, SUB, AND, OR and XOR produce the sum, difference or bitwise result of the two operands, truncated to the operand size.
- R3: Size encoding is 0/1/2/3 for 1/2/4/8 bytes. For sizes 0 and 1 the bits above the operand size are copied from `dst_old`. For size 2 the bits above 31 are zero. For size 3 the whole result is used.
- R4: ADC computes src1+op2+CF and SBB computes src1-op2-CF, where CF is the stored carry flag before the operation.
- R5: For ADD and ADC, CF is the carry out of the top bit at the operand size. For SUB and SBB, CF is the borrow, which is set when the unsigned minuend is less than the subtrahend plus any borrow-in.
- R6: For the four arithmetic opcodes, OF is set when the signed result at the operand size lies outside the signed range of that size.
- R7: ZF is set when the truncated result is zero. SF is the top bit of the result at the operand size. PF is set when the low result byte has an even number of ones.
- R8: AND, OR and XOR produce CF=0 and OF=0.
- R9: Flag bit positions in both `flag_mask` and `flags_out` are CF=0, PF=1, ZF=2, SF=3, OF=4. Only flags whose mask bit is 1 take the new value. A zero mask leaves every flag unchanged.
- R10: MOV writes op2 at the operand size, merged as in R3, only when the condition holds. The condition `cond_sel[2:0]` selects one of: 0 always, 1 CF, 2 ZF, 3 SF, 4 OF, 5 PF, 6 CF or ZF, 7 SF xor OF. `cond_sel[3]`=1 inverts the selected condition. A failed condition leaves the result equal to `dst_old`. MOV never changes the flags.
- R11: Results and flags update one clock after an accepted operation, and `res_valid` follows `op_valid` one cycle later. While `op_valid` is low, `res_out` and `flags_out` hold. Reset clears `res_out`, `res_valid` and `flags_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Opcode |
| op_size | input | 2 | Operand size code |
| use_imm | input | 1 | Select immediate as second operand |
| src1 | input | 64 | First source |
| src2 | input | 64 | Register second source |
| imm | input | 8 | Immediate second source |
| dst_old | input | 64 | Previous destination value |
| flag_mask | input | 5 | Per-flag update enable |
| cond_sel | input | 4 | Move condition select |
| res_out | output | 64 | Registered merged result |
| res_valid | output | 1 | Result updated this cycle |
| flags_out | output | 5 | Stored condition flags |

## Verification
Every opcode runs at every size against an operand set that straddles the sign and carry boundaries at bytes 1, 2, 4 and 8 (zero, one, 0x7F, 0x80, 0x7FFF, 0x8000_0000, the largest positive value and all ones), in both register and immediate form. These pairs separate carry from overflow, and borrow from wrap-around. The update mask and the move condition rotate over the sweep, so the stored carry entering ADC and SBB changes over time, and masked-out flags are shown to persist. A shifting destination pattern shows whether upper bytes were kept or zeroed.

// File: rtl/szalu_pkg.sv
package szalu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_MOV = 3'd7
  } alu_op_e;

  localparam int NFLAG  = 5;
  localparam int FLG_CF = 0;
  localparam int FLG_PF = 1;
  localparam int FLG_ZF = 2;
  localparam int FLG_SF = 3;
  localparam int FLG_OF = 4;

  localparam int NSIZE  = 4;
  localparam int SIZE_W = $clog2(NSIZE);

endpackage

// File: rtl/szalu_arith.sv
module szalu_arith
  import szalu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  alu_op_e            op,
  input  logic [SIZE_W-1:0]  size,
  input  logic [DATA_W-1:0]  opa,
  input  logic [DATA_W-1:0]  opb,
  input  logic               cf_in,
  output logic [DATA_W-1:0]  result,
  output logic [NFLAG-1:0]   flags_calc
);

  logic              is_sub;
  logic              is_logic;
  logic              cin;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] logic_res;
  logic [DATA_W:0]   sum;

  // per-size boundary information
  logic [NSIZE-1:0]  cy_l;
  logic [NSIZE-1:0]  sa_l;
  logic [NSIZE-1:0]  sb_l;
  logic [NSIZE-1:0]  sr_l;
  logic [NSIZE-1:0]  zero_l;

  always_comb begin
    is_sub   = (op == OP_SUB) || (op == OP_SBB);
    is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    case (op)
      OP_ADC:  cin = cf_in;
      OP_SUB:  cin = 1'b1;
      OP_SBB:  cin = ~cf_in;
      default: cin = 1'b0;
    endcase
  end

  // subtraction reuses the adder with the inverted operand
  assign b_eff = is_sub ? ~opb : opb;
  assign sum   = {1'b0, opa} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};

  always_comb begin
    case (op)
      OP_AND:  logic_res = opa & opb;
      OP_OR:   logic_res = opa | opb;
      default: logic_res = opa ^ opb;
    endcase
  end

  assign result = is_logic ? logic_res : sum[DATA_W-1:0];

  for (genvar g = 0; g < NSIZE; g++) begin : g_lane
    localparam int LB = 8 << g;
    if (LB >= DATA_W) begin : g_full
      assign cy_l[g]   = sum[DATA_W];
      assign zero_l[g] = (result == '0);
    end else begin : g_part
      // carry into bit LB recovered from the sum bit and its inputs
      assign cy_l[g]   = sum[LB] ^ opa[LB] ^ b_eff[LB];
      assign zero_l[g] = (result[LB-1:0] == '0);
    end
    assign sa_l[g] = opa[LB-1];
    assign sb_l[g] = b_eff[LB-1];
    assign sr_l[g] = result[LB-1];
  end

  always_comb begin
    flags_calc         = '0;
    flags_calc[FLG_CF] = is_logic ? 1'b0 : (is_sub ? ~cy_l[size] : cy_l[size]);
    flags_calc[FLG_OF] = is_logic ? 1'b0 :
                         ((sa_l[size] == sb_l[size]) && (sr_l[size] != sa_l[size]));
    flags_calc[FLG_ZF] = zero_l[size];
    flags_calc[FLG_SF] = sr_l[size];
    flags_calc[FLG_PF] = ~^result[7:0];
  end

endmodule

// File: rtl/szalu_cond.sv
module szalu_cond
  import szalu_pkg::*;
#(
  parameter int COND_W = 4
) (
  input  logic [NFLAG-1:0]  flags,
  input  logic [COND_W-1:0] cond,
  output logic              take
);

  logic base;

  always_comb begin
    case (cond[2:0])
      3'd0:    base = 1'b1;
      3'd1:    base = flags[FLG_CF];
      3'd2:    base = flags[FLG_ZF];
      3'd3:    base = flags[FLG_SF];
      3'd4:    base = flags[FLG_OF];
      3'd5:    base = flags[FLG_PF];
      3'd6:    base = flags[FLG_CF] | flags[FLG_ZF];
      default: base = flags[FLG_SF] ^ flags[FLG_OF];
    endcase
    take = base ^ cond[COND_W-1];
  end

endmodule

// File: rtl/szalu_merge.sv
module szalu_merge
  import szalu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [SIZE_W-1:0] size,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] new_val,
  output logic [DATA_W-1:0] merged
);

  localparam int B1 = 8;
  localparam int B2 = 16;
  localparam int B4 = 32;

  always_comb begin
    case (size)
      2'd0:    merged = {old_val[DATA_W-1:B1], new_val[B1-1:0]};
      2'd1:    merged = {old_val[DATA_W-1:B2], new_val[B2-1:0]};
      2'd2:    merged = {{(DATA_W-B4){1'b0}}, new_val[B4-1:0]};
      default: merged = new_val;
    endcase
  end

endmodule

// File: rtl/szmerge_alu.sv
module szmerge_alu
  import szalu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8,
  parameter int COND_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 op_valid,
  input  logic [2:0]           op_code,
  input  logic [SIZE_W-1:0]    op_size,
  input  logic                 use_imm,
  input  logic [DATA_W-1:0]    src1,
  input  logic [DATA_W-1:0]    src2,
  input  logic [IMM_W-1:0]     imm,
  input  logic [DATA_W-1:0]    dst_old,
  input  logic [NFLAG-1:0]     flag_mask,
  input  logic [COND_W-1:0]    cond_sel,
  output logic [DATA_W-1:0]    res_out,
  output logic                 res_valid,
  output logic [NFLAG-1:0]     flags_out
);

  localparam int EXT_W = DATA_W - IMM_W;

  alu_op_e           op;
  logic [DATA_W-1:0] op2;
  logic [DATA_W-1:0] alu_res;
  logic [NFLAG-1:0]  flags_new;
  logic [DATA_W-1:0] pre_merge;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] next_res;
  logic              take;
  logic [DATA_W-1:0] res_q;
  logic              vld_q;
  logic [NFLAG-1:0]  flags_q;

  assign op  = alu_op_e'(op_code);
  assign op2 = use_imm ? {{EXT_W{1'b0}}, imm} : src2;

  szalu_arith #(.DATA_W(DATA_W)) u_arith (
    .op         (op),
    .size       (op_size),
    .opa        (src1),
    .opb        (op2),
    .cf_in      (flags_q[FLG_CF]),
    .result     (alu_res),
    .flags_calc (flags_new)
  );

  szalu_cond #(.COND_W(COND_W)) u_cond (
    .flags (flags_q),
    .cond  (cond_sel),
    .take  (take)
  );

  assign pre_merge = (op == OP_MOV) ? op2 : alu_res;

  szalu_merge #(.DATA_W(DATA_W)) u_merge (
    .size    (op_size),
    .old_val (dst_old),
    .new_val (pre_merge),
    .merged  (merged)
  );

  assign next_res = ((op == OP_MOV) && !take) ? dst_old : merged;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      vld_q   <= 1'b0;
      flags_q <= '0;
    end else begin
      vld_q <= op_valid;
      if (op_valid) begin
        res_q <= next_res;
        if (op != OP_MOV) begin
          flags_q <= (flags_q & ~flag_mask) | (flags_new & flag_mask);
        end
      end
    end
  end

  assign res_out   = res_q;
  assign res_valid = vld_q;
  assign flags_out = flags_q;

  AST_MASK_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op_valid && flag_mask == '0) |=> $stable(flags_out)); // R9

  AST_MOV_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd7) |=> $stable(flags_out)); // R10

  AST_SZ4_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_size == 2'd2 && op_code != 3'd7) |=> (res_out[DATA_W-1:32] == '0)); // R3

  AST_SZ1_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_size == 2'd0 && op_code != 3'd7)
      |=> (res_out[DATA_W-1:8] == $past(dst_old[DATA_W-1:8]))); // R3

  AST_LOGIC_CO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code >= 3'd4 && op_code <= 3'd6 && flag_mask[FLG_CF] && flag_mask[FLG_OF])
      |=> (!flags_out[FLG_CF] && !flags_out[FLG_OF])); // R8

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!res_valid && $stable(res_out) && $stable(flags_out))); // R11

endmodule

// File: tb/szmerge_alu_test.sv
module szmerge_alu_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [1:0]  op_size;
  logic        use_imm;
  logic [63:0] src1, src2, dst_old;
  logic [7:0]  imm;
  logic [4:0]  flag_mask;
  logic [3:0]  cond_sel;
  logic [63:0] res_out;
  logic        res_valid;
  logic [4:0]  flags_out;

  int n_run = 0;
  int n_bad = 0;

  always #4 clk = ~clk;   // 125 MHz

  szmerge_alu uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_size(op_size), .use_imm(use_imm), .src1(src1), .src2(src2),
    .imm(imm), .dst_old(dst_old), .flag_mask(flag_mask), .cond_sel(cond_sel),
    .res_out(res_out), .res_valid(res_valid), .flags_out(flags_out)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int i);
    case (i)
      0: return 64'h0;
      1: return 64'h1;
      2: return 64'h7f;
      3: return 64'h80;
      4: return 64'h7fff;
      5: return 64'h8000_0000;
      6: return 64'h7fff_ffff_ffff_ffff;
      default: return 64'hffff_ffff_ffff_ffff;
    endcase
  endfunction

  // bench reference; flag order {OF,SF,ZF,PF,CF}
  function automatic void model(input int op, input int sz, input logic ui,
                                input logic [63:0] s1, input logic [63:0] s2,
                                input logic [7:0] im, input logic [63:0] dst,
                                input logic [4:0] msk, input logic [3:0] cnd,
                                inout logic [4:0] fl, output logic [63:0] res);
    int n;
    logic [63:0] m, a, b, r;
    logic [64:0] w;
    logic cc, cf, of, base, take;
    logic signed [66:0] sa, sb, sr, hi, lo, cs;
    logic [4:0] calc;
    n  = 8 << sz;
    m  = (n == 64) ? 64'hffff_ffff_ffff_ffff : ((64'd1 << n) - 64'd1);
    a  = s1 & m;
    b  = (ui ? {56'd0, im} : s2) & m;
    sa = {3'b000, a};
    if (a[n-1]) sa = sa - (67'sd1 <<< n);
    sb = {3'b000, b};
    if (b[n-1]) sb = sb - (67'sd1 <<< n);
    hi = (67'sd1 <<< (n-1)) - 67'sd1;
    lo = -(67'sd1 <<< (n-1));
    cc = 1'b0; cf = 1'b0; of = 1'b0; r = '0;
    case (op)
      0, 1: begin
        cc = (op == 1) ? fl[0] : 1'b0;
        cs = cc ? 67'sd1 : 67'sd0;
        w  = {1'b0, a} + {1'b0, b} + {64'd0, cc};
        r  = w[63:0] & m;
        cf = w[n];
        sr = sa + sb + cs;
        of = (sr > hi) || (sr < lo);
      end
      2, 3: begin
        cc = (op == 3) ? fl[0] : 1'b0;
        cs = cc ? 67'sd1 : 67'sd0;
        r  = (a - b - {63'd0, cc}) & m;
        cf = ({1'b0, a} < ({1'b0, b} + {64'd0, cc}));
        sr = sa - sb - cs;
        of = (sr > hi) || (sr < lo);
      end
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      default: r = b;
    endcase
    if (op != 7) begin
      calc = {of, r[n-1], (r == 64'd0), ~^r[7:0], cf};
      fl   = (fl & ~msk) | (calc & msk);
      take = 1'b1;
    end else begin
      case (cnd[2:0])
        3'd0: base = 1'b1;
        3'd1: base = fl[0];
        3'd2: base = fl[2];
        3'd3: base = fl[3];
        3'd4: base = fl[4];
        3'd5: base = fl[1];
        3'd6: base = fl[0] | fl[2];
        default: base = fl[3] ^ fl[4];
      endcase
      take = base ^ cnd[3];
    end
    if (!take)          res = dst;
    else if (sz == 0)   res = {dst[63:8], r[7:0]};
    else if (sz == 1)   res = {dst[63:16], r[15:0]};
    else if (sz == 2)   res = {32'd0, r[31:0]};
    else                res = r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_bad++;
    $display("FAIL R11 watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    logic [4:0]  mfl;
    logic [63:0] eres;
    logic [63:0] hold_res;
    logic [4:0]  hold_fl;
    logic [4:0]  mlist [8];
    int k;
    mlist[0] = 5'h1f; mlist[1] = 5'h00; mlist[2] = 5'h01; mlist[3] = 5'h10;
    mlist[4] = 5'h15; mlist[5] = 5'h0a; mlist[6] = 5'h1f; mlist[7] = 5'h13;
    mfl = '0;
    rst = 1'b1; op_valid = 1'b0; op_code = '0; op_size = '0; use_imm = 1'b0;
    src1 = '0; src2 = '0; imm = '0; dst_old = '0; flag_mask = '0; cond_sel = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset res", res_out, 64'd0);
    chk("R11 reset valid", {63'd0, res_valid}, 64'd0);
    chk("R11 reset flags", {59'd0, flags_out}, 64'd0);
    rst = 1'b0;

    // R11 single accepted op, then an idle cycle
    op_valid = 1'b1; op_code = 3'd0; op_size = 2'd3; src1 = 64'd5; src2 = 64'd7;
    flag_mask = 5'h1f; dst_old = 64'd0;
    model(0, 3, 1'b0, src1, src2, imm, dst_old, flag_mask, cond_sel, mfl, eres);
    @(negedge clk);
    chk("R11 valid after op", {63'd0, res_valid}, 64'd1);
    chk("R2 add 5+7", res_out, eres);
    hold_res = res_out; hold_fl = flags_out;
    op_valid = 1'b0; op_code = 3'd2; src1 = 64'd1; src2 = 64'd9;
    @(negedge clk);
    chk("R11 idle valid low", {63'd0, res_valid}, 64'd0);
    chk("R11 idle res hold", res_out, hold_res);
    chk("R11 idle flags hold", {59'd0, flags_out}, {59'd0, hold_fl});

    k = 0;
    for (int op = 0; op < 8; op++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int i = 0; i < 8; i++) begin
          for (int j = 0; j < 8; j++) begin
            for (int ui = 0; ui < 2; ui++) begin
              k++;
              op_valid  = 1'b1;
              op_code   = 3'(op);
              op_size   = 2'(sz);
              use_imm   = ui[0];
              src1      = pat(i);
              src2      = pat(j);
              imm       = pat(j)[7:0] ^ 8'(j * 3);
              dst_old   = 64'ha5a5_5a5a_c3c3_3c3c ^ (64'(k) << 7);
              flag_mask = mlist[k % 8];
              cond_sel  = 4'(k % 16);
              model(op, sz, ui[0], src1, src2, imm, dst_old, flag_mask, cond_sel, mfl, eres);
              @(negedge clk);
              // low part of result
              if (op == 7)             chk("R10 move result", res_out, eres);
              else if (ui == 1)        chk("R1 immediate result", res_out[7:0], eres[7:0]);
              else if (op == 1 || op == 3) chk("R4 carry-chained result", res_out[7:0], eres[7:0]);
              else                     chk("R2 result", res_out[7:0], eres[7:0]);
              // full merged value
              chk("R3 merged result", res_out, eres);
              // flags
              if (op >= 4 && op <= 6) begin
                chk("R8 logic CF", {63'd0, flags_out[0]}, {63'd0, mfl[0]});
                chk("R8 logic OF", {63'd0, flags_out[4]}, {63'd0, mfl[4]});
              end else begin
                chk("R5 carry flag", {63'd0, flags_out[0]}, {63'd0, mfl[0]});
                chk("R6 overflow flag", {63'd0, flags_out[4]}, {63'd0, mfl[4]});
              end
              chk("R7 ZF SF PF", {61'd0, flags_out[3:1]}, {61'd0, mfl[3:1]});
              chk("R9 masked flag set", {59'd0, flags_out}, {59'd0, mfl});
            end
          end
        end
      end
    end
    op_valid = 1'b0;
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule